// File: doc/BRIEF.md
# Charge Pump Start-up Sequencer and Short-Circuit Latch

This block sequences the start-up of a two-rail charge pump controller and shuts it down when a rail is shorted. It runs on the free-running internal oscillator, whatever clock the pump itself uses. When the enable input goes high it starts the pump. After a programmable soft-start interval it releases the regulators. It ignores over-current reports until a longer masking interval has passed, because inrush currents during start-up look like shorts.

Once the masking interval is over, an over-current report on either the positive or the negative rail, each passed through a two-flop synchroniser, latches the block off. The pump and regulators stay off until enable is taken low and then high again. That cycle starts a fresh, fully timed sequence. One saturating counter times both intervals. The defaults of 18800 and 36000 ticks correspond to 9.4 ms and 18 ms on a 2 MHz clock.

Top module: `pump_start_seq`

## Requirements
- R1: With `en_i` sampled low at a rising edge, `pump_run_o`, `reg_start_o` and `fault_o` are all low after that edge.
- R2: When `en_i` is sampled high while the block is off, `pump_run_o` goes high at that same edge, and `reg_start_o` stays low.
- R3: `reg_start_o` rises exactly `START_TICKS` rising edges after `pump_run_o` rises, and it stays high while the block keeps running.
- R4: Over-current flags on either rail have no effect while fewer than `MASK_TICKS` edges have passed since `pump_run_o` rose. A flag that is held from the start sets `fault_o` at edge `MASK_TICKS`+2, counted from the edge that started the pump.
- R5: After the masking interval, a flag on `oc_pos_i` or on `oc_neg_i` sets `fault_o` at the third rising edge that samples the flag high, which covers two synchroniser stages and the latch. At that same edge `pump_run_o` and `reg_start_o` go low.
- R6: While `en_i` stays high, `fault_o` stays high and the pump stays off, whatever the flags do.
- R7: Driving `en_i` low clears the fault at the next edge. Driving it high again restarts the full sequence, with `reg_start_o` low for `START_TICKS` edges.
- R8: Driving `rst_ni` low clears all outputs at once, without a clock edge. After release, the block behaves as it does when enable was low.
- R9: The interval counter saturates and does not wrap. In a long fault-free run, `reg_start_o` stays high and `fault_o` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running internal oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | System enable, active high |
| oc_pos_i | input | 1 | Over-current flag, positive rail |
| oc_neg_i | input | 1 | Over-current flag, negative rail |
| pump_run_o | output | 1 | Charge pump run enable |
| reg_start_o | output | 1 | Regulator start; high once soft-start has ended |
| fault_o | output | 1 | Short-circuit latch status |

## Verification
The bench builds the block with `START_TICKS` = 20 and `MASK_TICKS` = 40. With these values, a test can cross both thresholds in a few dozen edges, so every edge on either side of each threshold is checked. The counter is only 6 bits wide at these values, so a run of a few hundred edges passes the point where a wrapping counter would return to zero and shows that it saturates. The same short intervals make it cheap to repeat several trip, retry and reset sequences one after another.

// File: rtl/pump_seq_pkg.sv
package pump_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_OFF     = 2'd0,
    SEQ_ACTIVE  = 2'd1,
    SEQ_TRIPPED = 2'd2
  } seq_state_e;
endpackage

// File: rtl/oc_sync.sv
module oc_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int unsigned START_TICKS = 18800,
  parameter int unsigned MASK_TICKS  = 36000,
  localparam int unsigned CW = $clog2(MASK_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic start_done_o,
  output logic mask_done_o
);
  localparam logic [CW-1:0] START_V = CW'(START_TICKS);
  localparam logic [CW-1:0] MASK_V  = CW'(MASK_TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i)          cnt_q <= '0;
    else if (cnt_q != MASK_V) cnt_q <= cnt_q + 1'b1;
  end

  assign start_done_o = run_i && (cnt_q >= START_V);
  assign mask_done_o  = run_i && (cnt_q >= MASK_V);
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import pump_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic oc_any_i,
  input  logic mask_done_i,
  output logic active_o,
  output logic tripped_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!en_i) state_d = SEQ_OFF;
    else begin
      unique case (state_q)
        SEQ_OFF:     state_d = SEQ_ACTIVE;
        SEQ_ACTIVE:  if (mask_done_i && oc_any_i) state_d = SEQ_TRIPPED;
        SEQ_TRIPPED: state_d = SEQ_TRIPPED;
        default:     state_d = SEQ_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_OFF;
    else         state_q <= state_d;
  end

  assign active_o  = (state_q == SEQ_ACTIVE);
  assign tripped_o = (state_q == SEQ_TRIPPED);
endmodule

// File: rtl/pump_start_seq.sv
module pump_start_seq #(
  parameter int unsigned START_TICKS = 18800,
  parameter int unsigned MASK_TICKS  = 36000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic oc_pos_i,
  input  logic oc_neg_i,
  output logic pump_run_o,
  output logic reg_start_o,
  output logic fault_o
);
  localparam int unsigned N_RAILS = 2;

  logic [N_RAILS-1:0] oc_sync;
  logic active, tripped, start_done, mask_done;

  oc_sync #(.WIDTH(N_RAILS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({oc_neg_i, oc_pos_i}),
    .sync_o  (oc_sync)
  );

  seq_timer #(.START_TICKS(START_TICKS), .MASK_TICKS(MASK_TICKS)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (active),
    .start_done_o (start_done),
    .mask_done_o  (mask_done)
  );

  seq_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .oc_any_i    (|oc_sync),
    .mask_done_i (mask_done),
    .active_o    (active),
    .tripped_o   (tripped)
  );

  assign pump_run_o  = active;
  assign reg_start_o = start_done;
  assign fault_o     = tripped;
endmodule

// File: rtl/pump_start_seq_chk.sv
module pump_start_seq_chk #(
  parameter int unsigned START_TICKS = 18800,
  parameter int unsigned MASK_TICKS  = 36000,
  localparam int unsigned CW = $clog2(MASK_TICKS + 2)
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic pump_run_o,
  input logic reg_start_o,
  input logic fault_o
);
  logic [CW-1:0] run_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             run_cnt_q <= '0;
    else if (!pump_run_o)                    run_cnt_q <= '0;
    else if (run_cnt_q != CW'(MASK_TICKS))   run_cnt_q <= run_cnt_q + 1'b1;
  end

  AST_EN_LOW_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!pump_run_o && !reg_start_o && !fault_o)); // R1
  AST_REG_AFTER_SOFTSTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_start_o) |-> (run_cnt_q == CW'(START_TICKS))); // R3
  AST_REG_NEEDS_PUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_start_o |-> pump_run_o); // R3
  AST_NO_TRIP_IN_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> ($past(pump_run_o) && run_cnt_q >= CW'(MASK_TICKS))); // R4
  AST_FAULT_FORCES_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!pump_run_o && !reg_start_o)); // R5
  AST_FAULT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && en_i) |=> fault_o); // R6
endmodule

bind pump_start_seq pump_start_seq_chk #(
  .START_TICKS(START_TICKS),
  .MASK_TICKS (MASK_TICKS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .pump_run_o  (pump_run_o),
  .reg_start_o (reg_start_o),
  .fault_o     (fault_o)
);

// File: tb/pump_start_seq_bench.sv
`timescale 1ns/1ps
module pump_start_seq_bench;
  localparam int START = 20;
  localparam int MASK  = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, ocp = 1'b0, ocn = 1'b0;
  logic pump, regs, flt;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  pump_start_seq #(.START_TICKS(START), .MASK_TICKS(MASK)) u_pump_start_seq (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .oc_pos_i(ocp), .oc_neg_i(ocn),
    .pump_run_o(pump), .reg_start_o(regs), .fault_o(flt)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [2:0] got, input logic [2:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: {pump,reg,fault} got %b expected %b", req, got, exp);
    end
  endtask

  function automatic logic [2:0] outs();
    return {pump, regs, flt};
  endfunction

  task automatic go_off();
    en = 0; ocp = 0; ocn = 0;
    tick(3);
  endtask

  task automatic t_reset();
    chk("R8 reset state", outs(), 3'b000);
    rst_n = 1; tick(2);
    chk("R1 idle with enable low", outs(), 3'b000);
  endtask

  task automatic t_startup();
    en = 1; tick(1);
    chk("R2 pump on at first edge", outs(), 3'b100);
    tick(START - 1);
    chk("R3 reg still low before soft-start end", outs(), 3'b100);
    tick(1);
    chk("R3 reg high at soft-start end", outs(), 3'b110);
    en = 0; tick(1);
    chk("R1 enable low stops all", outs(), 3'b000);
    go_off();
  endtask

  task automatic t_mask_pulse();
    en = 1; tick(5);
    ocp = 1; tick(4); ocp = 0;
    tick(10);
    ocn = 1; tick(3); ocn = 0;
    tick(MASK);
    chk("R4 pulses within mask ignored", outs(), 3'b110);
    go_off();
  endtask

  task automatic t_mask_held();
    ocp = 1; en = 1; tick(MASK + 1);
    chk("R4 held flag ignored until mask end", outs(), 3'b110);
    tick(1);
    chk("R4 held flag trips right after mask", outs(), 3'b001);
    go_off();
  endtask

  task automatic t_trip(input bit neg);
    en = 1; tick(MASK + 10);
    if (neg) ocn = 1; else ocp = 1;
    tick(2);
    chk(neg ? "R5 neg flag not yet through sync" : "R5 pos flag not yet through sync", outs(), 3'b110);
    tick(1);
    chk(neg ? "R5 neg flag latches off" : "R5 pos flag latches off", outs(), 3'b001);
    ocp = 0; ocn = 0; tick(50);
    chk("R6 fault held with flags cleared", outs(), 3'b001);
    ocp = 1; tick(5); ocp = 0; tick(2);
    chk("R6 fault held after more flags", outs(), 3'b001);
  endtask

  task automatic t_retry();
    en = 0; tick(1);
    chk("R7 enable low clears fault", outs(), 3'b000);
    en = 1; tick(1);
    chk("R7 restart pump on", outs(), 3'b100);
    tick(START - 1);
    chk("R7 restart reg still low", outs(), 3'b100);
    tick(1);
    chk("R7 restart reg high", outs(), 3'b110);
    go_off();
  endtask

  task automatic t_saturate();
    en = 1; tick(300);
    chk("R9 long run no wrap", outs(), 3'b110);
    go_off();
  endtask

  task automatic t_async_reset();
    en = 1; tick(START + 5);
    #1 rst_n = 0; #1;
    n_chk++;
    if ({pump, regs, flt} !== 3'b000) begin
      n_fail++;
      $display("FAIL R8 async clear: got %b expected 000", {pump, regs, flt});
    end
    tick(2); rst_n = 1; tick(1);
    chk("R8 restart after release", outs(), 3'b100);
    tick(START);
    chk("R8 full soft-start after release", outs(), 3'b110);
    go_off();
  endtask

  initial begin
    tick(2);
    t_reset();
    t_startup();
    t_mask_pulse();
    t_mask_held();
    t_trip(1'b0);
    t_retry();
    t_trip(1'b1);
    t_retry();
    t_saturate();
    t_async_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule